// File: doc/BRIEF.md
# Half-Duplex Ethernet Transmit Backoff and Collision Window

This block handles collisions on the transmit side of a half-duplex Ethernet MAC. Its timers run on a strobe that is high for one clock cycle per bit time. After a transmission request, the block defers while the medium is busy. It opens a collision window once the frame is under way. When a collision falls inside that window, it schedules a retry after a backoff wait. A collision after the window has closed is reported as late. Repeated collisions end in an abort. Carrier sense that holds the request for too long ends in an excessive-deferral report.

The MAC's transmit sequencer drives a set of one-cycle strobes into the block: transmission request, start of preamble, end of start-frame delimiter, collision and successful completion. It also drives the carrier-sense level. Three static configuration bits change the behaviour. The first replaces the random wait with a fixed one-slot wait. The second chooses whether the collision window opens at the first preamble bit or after the delimiter. The third masks excessive-deferral reporting. The slot time, the deferral limit and the attempt limit are parameters. Their defaults are 512 bit times, 24288 bit times and 16 attempts.

The block moves through four phases: idle, deferring, active and backing off. A retry grant moves it from backing off back to deferring. While deferring, the next start-of-preamble strobe starts the retried attempt.

Top module: `eth_tx_backoff`

## Requirements
- R1: After a synchronous active-low reset, retry_grant, late_col, exc_col_abort, exd_status and exd_inc are all 0.
- R2: With cfg_single_bo = 1, every in-window collision is followed by retry_grant going high exactly SLOT_BITS bit_tick strobes later. This holds for every attempt number. retry_grant is high for one cycle, and a start-of-preamble strobe in the following cycle starts the retry.
- R3: With cfg_single_bo = 0, the wait after the nth collision of a frame is r·SLOT_BITS bit ticks. r lies in 0..2^min(n,10)−1 and is drawn from a free-running 16-bit LFSR, so r is not the same across retries.
- R4: The collision that would be attempt number ATTEMPT_LIMIT (16) gives no grant. Instead it raises exc_col_abort for exactly one cycle, returns the block to idle and clears the attempt count.
- R5: With cfg_oow_sel = 0, the window opens at the end-of-SFD strobe. A collision sampled k bit ticks after that strobe is in-window for k ≤ SLOT_BITS and late for k = SLOT_BITS+1. A collision before the strobe is always in-window.
- R6: With cfg_oow_sel = 1, the window opens at the start-of-preamble strobe and the end-of-SFD strobe is ignored. A collision k ticks after the preamble strobe is in-window for k ≤ SLOT_BITS and late for k = SLOT_BITS+1.
- R7: A late collision sets late_col, gives no retry grant and returns the block to idle. late_col stays high until the next transmission request.
- R8: When carrier sense holds a deferring request for more than DEFER_LIMIT bit ticks, exd_status is set and stays set until the next request. At that moment exd_inc pulses for one cycle and the attempt ends.
- R9: With cfg_exd_dis = 1, neither exd_status nor exd_inc is ever raised, and the request stays deferred until its preamble starts.
- R10: A successful-completion strobe during the active phase clears the attempt count. The next frame then aborts only on its own 16th collision.
- R11: Backoff, window and deferral counters advance only on cycles where bit_tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | High for one cycle per bit time |
| tx_start | input | 1 | Transmission request strobe, accepted when idle |
| pre_start | input | 1 | First preamble bit strobe; starts the active phase from deferring |
| sfd_end | input | 1 | End of start-frame delimiter strobe |
| col_det | input | 1 | Collision strobe |
| crs | input | 1 | Carrier sense level |
| tx_done | input | 1 | Successful frame completion strobe |
| cfg_single_bo | input | 1 | 1: fixed one-slot backoff; 0: random backoff |
| cfg_oow_sel | input | 1 | 1: window opens at preamble; 0: after SFD |
| cfg_exd_dis | input | 1 | 1: mask excessive-deferral reporting |
| retry_grant | output | 1 | One-cycle grant at the end of the backoff wait |
| late_col | output | 1 | Late-collision flag, held until next request |
| exc_col_abort | output | 1 | One-cycle excessive-collision abort |
| exd_status | output | 1 | Excessive-deferral flag, held until next request |
| exd_inc | output | 1 | One-cycle excessive-deferral counter increment |

## Verification
The backoff wait is tried in two ways. Fixed mode, run for a full 16-collision run, separates an exact one-slot wait from an off-by-one count and from an early or late abort. Random mode, run over several frames of six collisions each, separates a wait that is a legal slot multiple within the growing range from one that is out of range or never varies. Collisions placed exactly on either side of the window edge are used under both window start selects, with a delimiter strobe inside the preamble-start case. These separate the two window origins and expose an off-by-one window length. Sustained carrier sense is applied with the deferral report unmasked, to fix the exact tick on which it fires, and masked, to show the request is still pending. A stretch with the tick held low shows that the counters advance only on tick cycles.

// File: rtl/eth_txbo_pkg.sv
// Package: shared phase type, backoff constants and the range-mask helper
// for the transmit backoff block. Assumes the standard exponent cap of 10.
package eth_txbo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DEFER   = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_BACKOFF = 2'd3
    } txbo_state_t;

    localparam int unsigned BO_EXP_CAP = 10;
    localparam int unsigned BO_RW      = BO_EXP_CAP;

    // Mask of 2^min(n,cap)-1 selecting the legal range of slot multipliers.
    function automatic logic [BO_RW-1:0] bo_mask(input int unsigned n);
        int unsigned  k;
        logic [BO_RW:0] t;
        k = (n > BO_EXP_CAP) ? BO_EXP_CAP : n;
        t = '0;
        t[0] = 1'b1;
        t = t << k;
        t = t - 1'b1;
        return t[BO_RW-1:0];
    endfunction

endpackage

// File: rtl/eth_txbo_lfsr.sv
// Module: free-running Galois LFSR providing backoff randomness.
// Assumes a nonzero seed; advances every clock so values depend on timing.
module eth_txbo_lfsr #(
    parameter int unsigned W     = 16,
    parameter int unsigned OUT_W = 10,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] q;

    // Shift the register one step per clock, feeding back the tap pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= q[0] ? ((q >> 1) ^ TAPS) : (q >> 1);
    end

    assign rnd = q[OUT_W-1:0];

    a_r3_lfsr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (q != '0) |=> (q != $past(q)));
endmodule

// File: rtl/eth_txbo_backoff.sv
// Module: backoff wait counter. On load it takes a slot multiplier (1 in
// fixed mode, masked random otherwise) and counts it down one slot per
// SLOT_BITS ticks while run is high. done is high when no slots remain.
module eth_txbo_backoff
    import eth_txbo_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 512,
    parameter int unsigned AW        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             run,
    input  logic             single,
    input  logic [AW-1:0]    attempt,
    input  logic [BO_RW-1:0] rnd,
    output logic             done
);
    localparam int unsigned SCW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

    logic [SCW-1:0]   slot_cnt;
    logic [BO_RW-1:0] slots_left;

    // Load the multiplier on a collision, then count slots down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt   <= '0;
            slots_left <= '0;
        end else if (load) begin
            slot_cnt   <= '0;
            slots_left <= single ? BO_RW'(1) : (rnd & bo_mask(int'(attempt)));
        end else if (run && tick && slots_left != '0) begin
            if (slot_cnt == SCW'(SLOT_BITS - 1)) begin
                slot_cnt   <= '0;
                slots_left <= slots_left - 1'b1;
            end else begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end
    end

    assign done = (slots_left == '0);

    a_r3_wait_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(load));
    a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !load) |=> ($stable(slots_left) && $stable(slot_cnt)));
endmodule

// File: rtl/eth_txbo_window.sv
// Module: collision-window timer. Arming starts the count (ignored once
// started); it counts ticks up to SLOT_BITS and then reports expiry until
// cleared. Clear has priority over arm.
module eth_txbo_window #(
    parameter int unsigned SLOT_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    input  logic arm,
    output logic expired
);
    localparam int unsigned WW = $clog2(SLOT_BITS + 1);

    logic          started;
    logic [WW-1:0] cnt;

    // Track whether the window is running and how many bit times elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            started <= 1'b0;
            cnt     <= '0;
        end else if (arm && !started) begin
            started <= 1'b1;
            cnt     <= '0;
        end else if (started && tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == WW'(SLOT_BITS));

    a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= WW'(SLOT_BITS));
    a_r7_expiry_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clear) |=> expired);
endmodule

// File: rtl/eth_txbo_defer.sv
// Module: deferral timer. Counts enabled ticks, saturating at LIMIT.
// over is high on an enabled tick when LIMIT ticks have already elapsed.
module eth_txbo_defer #(
    parameter int unsigned LIMIT = 24288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic over
);
    localparam int unsigned DW = $clog2(LIMIT + 1);

    logic [DW-1:0] cnt;

    // Accumulate deferral bit times while carrier holds the request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                     cnt <= '0;
        else if (count_en && cnt != DW'(LIMIT))  cnt <= cnt + 1'b1;
    end

    assign over = count_en && (cnt == DW'(LIMIT));

    a_r8_defer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DW'(LIMIT));
endmodule

// File: rtl/eth_tx_backoff.sv
// Module: transmit collision handling for a half-duplex MAC. Sequences
// idle, defer, active and backoff phases, counts attempts, and reports
// late collision, excessive collisions and excessive deferral. Assumes
// all strobes are one cycle wide and configuration changes only while idle.
module eth_tx_backoff
    import eth_txbo_pkg::*;
#(
    parameter int unsigned SLOT_BITS     = 512,
    parameter int unsigned DEFER_LIMIT   = 24288,
    parameter int unsigned ATTEMPT_LIMIT = 16,
    parameter logic [15:0] LFSR_SEED     = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic tx_start,
    input  logic pre_start,
    input  logic sfd_end,
    input  logic col_det,
    input  logic crs,
    input  logic tx_done,
    input  logic cfg_single_bo,
    input  logic cfg_oow_sel,
    input  logic cfg_exd_dis,
    output logic retry_grant,
    output logic late_col,
    output logic exc_col_abort,
    output logic exd_status,
    output logic exd_inc
);
    localparam int unsigned AW = $clog2(ATTEMPT_LIMIT + 1);

    txbo_state_t      state;
    logic [AW-1:0]    attempts;
    logic [AW-1:0]    att_next;
    logic [BO_RW-1:0] rnd;
    logic             bo_done, bo_load;
    logic             win_expired, win_arm, win_clear;
    logic             dfr_over, dfr_en, dfr_clear;

    assign att_next = attempts + 1'b1;
    assign bo_load  = (state == ST_ACTIVE) && col_det && !win_expired
                      && (att_next != AW'(ATTEMPT_LIMIT));

    assign win_arm   = ((state == ST_DEFER)  && pre_start && cfg_oow_sel)
                    || ((state == ST_ACTIVE) && sfd_end   && !cfg_oow_sel);
    assign win_clear = (state != ST_ACTIVE) && !win_arm;

    assign dfr_clear = (state != ST_DEFER);
    assign dfr_en    = (state == ST_DEFER) && !pre_start && crs && bit_tick;

    assign retry_grant = (state == ST_BACKOFF) && bo_done;

    eth_txbo_lfsr #(.W(16), .OUT_W(BO_RW), .SEED(LFSR_SEED)) lfsr_i (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    eth_txbo_backoff #(.SLOT_BITS(SLOT_BITS), .AW(AW)) backoff_i (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .load(bo_load),
        .run(state == ST_BACKOFF), .single(cfg_single_bo),
        .attempt(att_next), .rnd(rnd), .done(bo_done)
    );

    eth_txbo_window #(.SLOT_BITS(SLOT_BITS)) window_i (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .clear(win_clear),
        .arm(win_arm), .expired(win_expired)
    );

    eth_txbo_defer #(.LIMIT(DEFER_LIMIT)) defer_i (
        .clk(clk), .rst_n(rst_n), .clear(dfr_clear), .count_en(dfr_en),
        .over(dfr_over)
    );

    // Phase sequencing, attempt counting and the status flags and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            attempts      <= '0;
            late_col      <= 1'b0;
            exd_status    <= 1'b0;
            exd_inc       <= 1'b0;
            exc_col_abort <= 1'b0;
        end else begin
            exd_inc       <= 1'b0;
            exc_col_abort <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tx_start) begin
                        state      <= ST_DEFER;
                        late_col   <= 1'b0;
                        exd_status <= 1'b0;
                    end
                end
                ST_DEFER: begin
                    if (pre_start) begin
                        state <= ST_ACTIVE;
                    end else if (dfr_over && !cfg_exd_dis) begin
                        exd_status <= 1'b1;
                        exd_inc    <= 1'b1;
                        attempts   <= '0;
                        state      <= ST_IDLE;
                    end
                end
                ST_ACTIVE: begin
                    if (col_det) begin
                        if (win_expired) begin
                            late_col <= 1'b1;
                            attempts <= '0;
                            state    <= ST_IDLE;
                        end else if (att_next == AW'(ATTEMPT_LIMIT)) begin
                            exc_col_abort <= 1'b1;
                            attempts      <= '0;
                            state         <= ST_IDLE;
                        end else begin
                            attempts <= att_next;
                            state    <= ST_BACKOFF;
                        end
                    end else if (tx_done) begin
                        attempts <= '0;
                        state    <= ST_IDLE;
                    end
                end
                ST_BACKOFF: begin
                    if (bo_done) state <= ST_DEFER;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r4_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        exc_col_abort |=> !exc_col_abort);
    a_r4_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        exc_col_abort |-> (attempts == '0 && state == ST_IDLE));
    a_r7_late_from_col: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(late_col) |-> ($past(col_det) && $past(state) == ST_ACTIVE));
    a_r8_inc_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        exd_inc |-> exd_status);
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_exd_dis && $past(cfg_exd_dis)) |-> !exd_inc);
    a_r2_grant_to_defer: assert property (@(posedge clk) disable iff (!rst_n)
        retry_grant |=> (state == ST_DEFER));
    a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && tx_done && !col_det) |=> (attempts == '0));
endmodule

// File: tb/eth_tx_backoff_tb_top.sv
// Bench: behavioural reference model compared every clock, plus directed
// scenarios for each requirement. Inputs change on the falling edge.
module eth_tx_backoff_tb_top;
    localparam int S   = 16;
    localparam int LIM = 40;
    localparam int WD  = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b1, tx_start = 1'b0, pre_start = 1'b0, sfd_end = 1'b0;
    logic col_det = 1'b0, crs = 1'b0, tx_done = 1'b0;
    logic cfg_single_bo = 1'b0, cfg_oow_sel = 1'b0, cfg_exd_dis = 1'b0;
    logic retry_grant, late_col, exc_col_abort, exd_status, exd_inc;

    int  total = 0, bad = 0;
    bit  run_chk = 1'b0, finished = 1'b0;

    // Reference model state (behavioural, integers).
    int m_st = 0, m_att = 0, m_late = 0, m_exd = 0, m_inc = 0, m_abt = 0;
    int m_dcnt = 0, m_wst = 0, m_wcnt = 0, m_el = 0, m_lo = 0, m_hi = 0;
    logic g_obs = 1'b0;

    always #10 clk = ~clk;

    eth_tx_backoff #(.SLOT_BITS(S), .DEFER_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_start(tx_start),
        .pre_start(pre_start), .sfd_end(sfd_end), .col_det(col_det),
        .crs(crs), .tx_done(tx_done), .cfg_single_bo(cfg_single_bo),
        .cfg_oow_sel(cfg_oow_sel), .cfg_exd_dis(cfg_exd_dis),
        .retry_grant(retry_grant), .late_col(late_col),
        .exc_col_abort(exc_col_abort), .exd_status(exd_status),
        .exd_inc(exd_inc)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference model: advance the expected behaviour on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_att = 0; m_late = 0; m_exd = 0; m_inc = 0; m_abt = 0;
            m_dcnt = 0; m_wst = 0; m_wcnt = 0; m_el = 0;
        end else begin
            m_inc = 0; m_abt = 0;
            case (m_st)
                0: if (tx_start) begin m_st = 1; m_dcnt = 0; m_late = 0; m_exd = 0; end
                1: begin
                    if (pre_start) begin
                        m_st = 2; m_wst = cfg_oow_sel ? 1 : 0; m_wcnt = 0;
                    end else if (crs && bit_tick) begin
                        if (m_dcnt == LIM) begin
                            if (!cfg_exd_dis) begin
                                m_exd = 1; m_inc = 1; m_st = 0; m_att = 0;
                            end
                        end else m_dcnt++;
                    end
                end
                2: begin
                    if (col_det) begin
                        if (m_wcnt == S) begin
                            m_late = 1; m_st = 0; m_att = 0;
                        end else begin
                            m_att++;
                            if (m_att == 16) begin
                                m_abt = 1; m_att = 0; m_st = 0;
                            end else begin
                                m_st = 3; m_el = 0;
                                m_lo = cfg_single_bo ? 1 : 0;
                                m_hi = cfg_single_bo ? 1 : ((1 << ((m_att > 10) ? 10 : m_att)) - 1);
                            end
                        end
                    end else if (tx_done) begin
                        m_st = 0; m_att = 0;
                    end else begin
                        if (m_wst != 0 && bit_tick && m_wcnt < S) m_wcnt++;
                        if (sfd_end && !cfg_oow_sel) m_wst = 1;
                    end
                end
                default: begin
                    if (g_obs) begin m_st = 1; m_dcnt = 0; end
                    else if (bit_tick) m_el++;
                end
            endcase
        end
    end

    // Compare the design with the model on every falling edge.
    always @(negedge clk) begin
        string tg, xt;
        if (rst_n && run_chk) begin
            tg = cfg_single_bo ? "R2" : "R3";
            xt = cfg_exd_dis ? "R9" : "R8";
            chk("R7", int'(late_col), m_late, "late_col vs model");
            chk("R4", int'(exc_col_abort), m_abt, "exc_col_abort vs model");
            chk(xt, int'(exd_status), m_exd, "exd_status vs model");
            chk(xt, int'(exd_inc), m_inc, "exd_inc vs model");
            if (m_st != 3)
                chk(tg, int'(retry_grant), 0, "grant outside backoff");
            else if (retry_grant)
                chk(tg, ((m_el % S) == 0 && (m_el / S) >= m_lo && (m_el / S) <= m_hi) ? 1 : 0,
                    1, "grant slot multiple in range");
            else
                chk(tg, (m_el >= m_hi * S) ? 1 : 0, 0, "grant overdue");
        end
        g_obs = retry_grant;
    end

    task automatic step;
        @(negedge clk);
    endtask

    task automatic pulse_start;
        tx_start = 1'b1; step; tx_start = 1'b0;
    endtask

    task automatic pulse_pre;
        pre_start = 1'b1; step; pre_start = 1'b0;
    endtask

    task automatic pulse_done;
        tx_done = 1'b1; step; tx_done = 1'b0;
    endtask

    // Collision now; wait for grant, abort or late flag; w counts ticks.
    task automatic col_wait(output bit gr, output bit ab, output int w);
        col_det = 1'b1; step; col_det = 1'b0;
        w = 0;
        while (!retry_grant && !exc_col_abort && !late_col && w < 20000) begin
            step; w++;
        end
        gr = retry_grant;
        ab = exc_col_abort;
        if (gr) step;
    endtask

    task automatic do_col(output bit gr, output bit ab, output int w);
        pulse_pre;
        col_wait(gr, ab, w);
    endtask

    initial begin
        bit gr, ab;
        int w, grants, r0, diff, seen;
        r0 = -1; diff = 0;
        repeat (3) step;
        rst_n = 1'b1;
        run_chk = 1'b1;
        step;
        chk("R1", int'(retry_grant), 0, "grant after reset");
        chk("R1", int'(late_col), 0, "late_col after reset");
        chk("R1", int'(exc_col_abort), 0, "abort after reset");
        chk("R1", int'(exd_status), 0, "exd_status after reset");
        chk("R1", int'(exd_inc), 0, "exd_inc after reset");

        // Fixed one-slot backoff across a full run of 16 collisions.
        cfg_single_bo = 1'b1;
        pulse_start;
        for (int i = 1; i <= 16; i++) begin
            do_col(gr, ab, w);
            if (i < 16) begin
                chk("R2", int'(gr), 1, "fixed mode grant");
                chk("R2", w, S, "fixed mode wait ticks");
            end else begin
                chk("R4", int'(ab), 1, "abort on 16th collision");
                chk("R4", int'(gr), 0, "no grant on 16th collision");
            end
        end
        step;
        chk("R4", int'(exc_col_abort), 0, "abort lasts one cycle");

        // Completion clears the attempt count.
        pulse_start;
        for (int i = 1; i <= 15; i++) do_col(gr, ab, w);
        pulse_pre; pulse_done;
        pulse_start;
        grants = 0;
        for (int i = 1; i <= 15; i++) begin
            do_col(gr, ab, w);
            if (gr) grants++;
        end
        chk("R10", grants, 15, "grants after completion cleared count");
        do_col(gr, ab, w);
        chk("R10", int'(ab), 1, "abort on own 16th collision");

        // Random backoff over several frames.
        cfg_single_bo = 1'b0;
        for (int f = 0; f < 6; f++) begin
            pulse_start;
            for (int n = 1; n <= 6; n++) begin
                do_col(gr, ab, w);
                chk("R3", int'(gr), 1, "random mode grant");
                chk("R3", w % S, 0, "wait is slot multiple");
                chk("R3", ((w / S) <= ((1 << n) - 1)) ? 1 : 0, 1, "multiplier in range");
                if (n >= 2) begin
                    if (r0 < 0) r0 = w / S;
                    else if (w / S != r0) diff = 1;
                end
            end
            pulse_pre; pulse_done;
        end
        chk("R3", diff, 1, "random multipliers vary");

        // Window opens after SFD.
        cfg_single_bo = 1'b1; cfg_oow_sel = 1'b0;
        pulse_start;
        pulse_pre;
        repeat (40) step;
        col_wait(gr, ab, w);
        chk("R5", int'(gr), 1, "collision before SFD in window");
        pulse_pre; step;
        sfd_end = 1'b1; step; sfd_end = 1'b0;
        repeat (S - 1) step;
        col_wait(gr, ab, w);
        chk("R5", int'(gr), 1, "collision at window edge in window");
        pulse_pre; step;
        sfd_end = 1'b1; step; sfd_end = 1'b0;
        repeat (S) step;
        col_det = 1'b1; step; col_det = 1'b0;
        chk("R5", int'(late_col), 1, "collision past window is late");
        seen = 0;
        for (int i = 0; i < 3 * S; i++) begin
            if (retry_grant) seen = 1;
            step;
        end
        chk("R7", seen, 0, "no grant after late collision");
        chk("R7", int'(late_col), 1, "late flag held");
        pulse_start;
        chk("R7", int'(late_col), 0, "late flag cleared by request");

        // Window opens at preamble.
        cfg_oow_sel = 1'b1;
        pulse_pre;
        repeat (S - 1) step;
        col_wait(gr, ab, w);
        chk("R6", int'(gr), 1, "preamble window edge in window");
        pulse_pre;
        repeat (4) step;
        sfd_end = 1'b1; step; sfd_end = 1'b0;
        repeat (S - 5) step;
        col_det = 1'b1; step; col_det = 1'b0;
        chk("R6", int'(late_col), 1, "preamble window past edge is late");
        cfg_oow_sel = 1'b0;

        // Excessive deferral reported.
        crs = 1'b1;
        pulse_start;
        repeat (LIM) step;
        chk("R8", int'(exd_status), 0, "no report at limit");
        step;
        chk("R8", int'(exd_status), 1, "report past limit");
        chk("R8", int'(exd_inc), 1, "increment pulse");
        step;
        chk("R8", int'(exd_inc), 0, "increment lasts one cycle");
        chk("R8", int'(exd_status), 1, "status held");

        // Excessive deferral masked.
        cfg_exd_dis = 1'b1;
        pulse_start;
        chk("R8", int'(exd_status), 0, "status cleared by request");
        seen = 0;
        for (int i = 0; i < 3 * LIM; i++) begin
            if (exd_inc || exd_status) seen = 1;
            step;
        end
        chk("R9", seen, 0, "masked deferral silent");
        crs = 1'b0;
        do_col(gr, ab, w);
        chk("R9", int'(gr), 1, "request still pending when masked");
        pulse_pre; pulse_done;
        cfg_exd_dis = 1'b0;

        // Tick gating.
        pulse_start;
        pulse_pre;
        bit_tick = 1'b0;
        col_det = 1'b1; step; col_det = 1'b0;
        seen = 0;
        for (int i = 0; i < 3 * S; i++) begin
            if (retry_grant) seen = 1;
            step;
        end
        chk("R11", seen, 0, "no progress without tick");
        bit_tick = 1'b1;
        w = 0;
        while (!retry_grant && w < 1000) begin step; w++; end
        chk("R11", w, S, "wait counted in ticks only");
        step;
        pulse_pre; pulse_done;
        step;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule